// File: doc/BRIEF.md
# Programmable Core and System Clock Enable Divider

This block turns a fast oscillator clock into two clock enables. One paces the processor core and the other paces the peripheral system. Each enable is a one-cycle strobe in the oscillator clock domain. The core ratio is a power of two, from 1 to 8. The system ratio is an integer from 1 to 15. Software sets both ratios with one write to a six-bit control word.

An accepted write does not take effect at once. It waits in a pending slot until both divider counters end their periods on the same cycle. At that point both counters restart together under the new ratios. No period is cut short or stretched, and no lock wait is needed.

A write is refused when its system ratio is zero, or when the system ratio is smaller than the core ratio, because the system clock must never run faster than the core clock. A refused write sets an error flag that stays set until reset. The read-back outputs always show the ratios in force, never the pending ones.

Top module: `vco_ratio_divider`

## Requirements
- R1: After reset the active core select is 0, meaning divide by 1. The active system select is 5 and the error flag is 0.
- R2: On a cycle with `wr_en` high, `wr_data[1:0]` is the core select and `wr_data[5:2]` is the system select. Core select code k gives a core divide of 2^k. System select code n gives a system divide of n.
- R3: A write whose system select is 0 leaves the active and pending ratios unchanged and sets the error flag.
- R4: A write whose system divide is smaller than its core divide leaves the active and pending ratios unchanged and sets the error flag. A system divide equal to the core divide is accepted.
- R5: `core_en` is high for exactly one cycle in every core-divide cycles. With a core divide of 1 it is high on every cycle.
- R6: `sys_en` is high for exactly one cycle in every system-divide cycles. For example, codes 1, 6 and 10 give one pulse per 1, 6 and 10 oscillator cycles.
- R7: An accepted ratio becomes active only on a clock edge that follows a cycle in which `core_en` and `sys_en` are both high. Both counters then restart together. A later accepted write replaces an earlier one that is still pending.
- R8: `act_core_sel` and `act_sys_sel` report the ratios in force, not a pending write.
- R9: Once set, the error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 6 | Control word: [1:0] core select, [5:2] system select |
| core_en | output | 1 | Core clock enable, one cycle per core period |
| sys_en | output | 1 | System clock enable, one cycle per system period |
| act_core_sel | output | 2 | Core select code in force |
| act_sys_sel | output | 4 | System select code in force |
| cfg_err | output | 1 | Sticky flag for a refused write |

## Verification
The assertions assume that `wr_data` carries a meaningful value only while `wr_en` is high. They also assume that reset is held low for at least one clock edge before any write. The checks for single-cycle pulses and aligned ratio changes depend on the counters starting from zero together, which reset guarantees.

The stimulus drives every write and the reset release half a cycle away from the sampling edge. It holds reset for several cycles at the start and once more partway through the run. Its writes cover accepted, zero-ratio and inverted-ratio words, some written back to back so that a pending value is replaced.

// File: rtl/ratio_pkg.sv
package ratio_pkg;

    // Field widths of the control word
    localparam int CSEL_W = 2;
    localparam int SSEL_W = 4;
    localparam int WORD_W = CSEL_W + SSEL_W;

    // Largest core divide is 2^(2^CSEL_W - 1)
    localparam int CORE_MAX = 1 << ((1 << CSEL_W) - 1);
    localparam int CCNT_W   = (CORE_MAX > 1) ? $clog2(CORE_MAX) : 1;
    localparam int SCNT_W   = SSEL_W;
    localparam int CMP_W    = ((CCNT_W + 1) > SSEL_W) ? (CCNT_W + 1) : SSEL_W;

    typedef struct packed {
        logic [SSEL_W-1:0] ssel;
        logic [CSEL_W-1:0] csel;
    } ratio_t;

    // Core divide as a number wide enough to compare against a system divide
    function automatic logic [CMP_W-1:0] core_divide(input logic [CSEL_W-1:0] sel);
        return CMP_W'(1) << sel;
    endfunction

endpackage

// File: rtl/ratio_check.sv
module ratio_check
    import ratio_pkg::*;
(
    input  ratio_t req,
    output logic   legal
);

    logic [CMP_W-1:0] cdiv;
    logic [CMP_W-1:0] sdiv;

    always_comb begin
        cdiv  = core_divide(req.csel);
        sdiv  = CMP_W'(req.ssel);
        legal = (req.ssel != '0) && (sdiv >= cdiv);
    end

endmodule

// File: rtl/div_counter.sv
module div_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] term_val,
    output logic             at_term
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_q;
    cnt_state_t st_d;

    always_comb begin
        at_term = (st_q.cnt >= term_val);
        st_d    = st_q;
        if (restart || at_term) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5 / R6: after a strobe, a period longer than one cycle brings a low cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (at_term && !restart && (term_val != '0)) |=> !at_term);

    // R7: the count never runs past the terminal value in force
    a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= term_val);

endmodule

// File: rtl/vco_ratio_divider.sv
module vco_ratio_divider
    import ratio_pkg::*;
#(
    parameter int RST_SSEL = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              core_en,
    output logic              sys_en,
    output logic [CSEL_W-1:0] act_core_sel,
    output logic [SSEL_W-1:0] act_sys_sel,
    output logic              cfg_err
);

    typedef struct packed {
        ratio_t act;
        ratio_t pend;
        logic   pend_v;
        logic   err;
    } ctl_state_t;

    ctl_state_t st_q;
    ctl_state_t st_d;

    ratio_t             wr_req;
    logic               wr_legal;
    logic               core_term;
    logic               sys_term;
    logic               adopt;
    logic [CCNT_W-1:0]  core_tv;
    logic [SCNT_W-1:0]  sys_tv;

    assign wr_req = ratio_t'(wr_data);

    ratio_check u_check (
        .req   (wr_req),
        .legal (wr_legal)
    );

    always_comb begin
        core_tv = CCNT_W'((1 << st_q.act.csel) - 1);
        sys_tv  = st_q.act.ssel - 1'b1;
    end

    div_counter #(.CNT_W(CCNT_W)) u_core_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (adopt),
        .term_val (core_tv),
        .at_term  (core_term)
    );

    div_counter #(.CNT_W(SCNT_W)) u_sys_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (adopt),
        .term_val (sys_tv),
        .at_term  (sys_term)
    );

    always_comb begin
        adopt = st_q.pend_v && core_term && sys_term;
        st_d  = st_q;
        if (adopt) begin
            st_d.act    = st_q.pend;
            st_d.pend_v = 1'b0;
        end
        if (wr_en) begin
            if (wr_legal) begin
                st_d.pend   = wr_req;
                st_d.pend_v = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act.csel <= '0;
            st_q.act.ssel <= SSEL_W'(RST_SSEL);
            st_q.pend     <= '0;
            st_q.pend_v   <= 1'b0;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_en      = core_term;
    assign sys_en       = sys_term;
    assign act_core_sel = st_q.act.csel;
    assign act_sys_sel  = st_q.act.ssel;
    assign cfg_err      = st_q.err;

    // R3: a zero system ratio never becomes active
    a_r3_no_zero_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        act_sys_sel != '0);

    // R4: the active system divide is never below the active core divide
    a_r4_sys_not_faster: assert property (@(posedge clk) disable iff (!rst_n)
        CMP_W'(act_sys_sel) >= core_divide(act_core_sel));

    // R7: ratios change only after a cycle with both strobes high
    a_r7_aligned_switch: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_core_sel != $past(act_core_sel)) || (act_sys_sel != $past(act_sys_sel)))
        |-> $past(core_en && sys_en));

    // R9: the error flag never falls outside reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cfg_err));

endmodule

// File: tb/vco_ratio_divider_tb.sv
module vco_ratio_divider_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       core_en;
    logic       sys_en;
    logic [1:0] act_core_sel;
    logic [3:0] act_sys_sel;
    logic       cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vco_ratio_divider u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .core_en      (core_en),
        .sys_en       (sys_en),
        .act_core_sel (act_core_sel),
        .act_sys_sel  (act_sys_sel),
        .cfg_err      (cfg_err)
    );

    typedef struct {
        bit ce;
        bit se;
        int c;
        int s;
        bit err;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model built from the requirements; pushes one expected item per edge
    int m_c, m_s, m_cc, m_sc, m_pc, m_ps;
    bit m_pv, m_err;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_c = 0; m_s = 5; m_cc = 0; m_sc = 0;
            m_pv = 0; m_pc = 0; m_ps = 0; m_err = 0;
        end else begin
            bit ct, st, ad;
            int wc, ws;
            ct = (m_cc == (1 << m_c) - 1);
            st = (m_sc == m_s - 1);
            ad = m_pv && ct && st;
            if (ad) begin
                m_c = m_pc; m_s = m_ps; m_pv = 0; m_cc = 0; m_sc = 0;
            end else begin
                m_cc = ct ? 0 : m_cc + 1;
                m_sc = st ? 0 : m_sc + 1;
            end
            if (wr_en) begin
                wc = int'(wr_data[1:0]);
                ws = int'(wr_data[5:2]);
                if (ws != 0 && ws >= (1 << wc)) begin
                    m_pc = wc; m_ps = ws; m_pv = 1;
                end else begin
                    m_err = 1;
                end
            end
        end
        begin
            exp_t e;
            e.ce  = (m_cc == (1 << m_c) - 1);
            e.se  = (m_sc == m_s - 1);
            e.c   = m_c;
            e.s   = m_s;
            e.err = m_err;
            exp_q.push_back(e);
        end
    end

    // Monitor: compare outputs half a cycle after each edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R5 core_en", int'(core_en), int'(e.ce));
            chk("R6 sys_en", int'(sys_en), int'(e.se));
            chk("R7 R8 act_core_sel", int'(act_core_sel), e.c);
            chk("R7 R8 act_sys_sel", int'(act_sys_sel), e.s);
            chk("R3 R4 R9 cfg_err", int'(cfg_err), int'(e.err));
        end
    end

    task automatic wr(input int c, input int s);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {4'(s), 2'(c)};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_pulses(input int n, output int nc, output int ns);
        nc = 0; ns = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            if (core_en) nc++;
            if (sys_en)  ns++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        int nc, ns;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        #1;
        chk("R1 reset core sel", int'(act_core_sel), 0);
        chk("R1 reset sys sel", int'(act_sys_sel), 5);
        chk("R1 reset err", int'(cfg_err), 0);

        // R6 code 6 with core divide 2
        wr(1, 6);
        idle(40);
        count_pulses(120, nc, ns);
        chk("R5 core pulses div2", nc, 60);
        chk("R6 sys pulses code6", ns, 20);

        // R6 code 1
        wr(0, 1);
        idle(20);
        count_pulses(120, nc, ns);
        chk("R6 sys pulses code1", ns, 120);

        // R6 code 10, R5 divide 1
        wr(0, 10);
        idle(20);
        count_pulses(120, nc, ns);
        chk("R5 core pulses div1", nc, 120);
        chk("R6 sys pulses code10", ns, 12);

        // R2 largest ratios
        wr(3, 15);
        idle(150);
        count_pulses(120, nc, ns);
        chk("R2 R5 core pulses div8", nc, 15);
        chk("R2 R6 sys pulses code15", ns, 8);

        // R3 zero system select
        wr(1, 0);
        idle(150);
        #1;
        chk("R3 err after zero", int'(cfg_err), 1);
        chk("R3 core sel kept", int'(act_core_sel), 3);
        chk("R3 sys sel kept", int'(act_sys_sel), 15);

        // R4 inverted ratio after reset
        do_reset();
        idle(2);
        #1;
        chk("R1 R9 err cleared by reset", int'(cfg_err), 0);
        wr(3, 4);
        idle(20);
        #1;
        chk("R4 err after inverted", int'(cfg_err), 1);
        chk("R4 sys sel kept", int'(act_sys_sel), 5);

        // R4 equal ratio accepted, R9 err stays
        wr(2, 4);
        idle(60);
        #1;
        chk("R4 equal accepted core", int'(act_core_sel), 2);
        chk("R4 equal accepted sys", int'(act_sys_sel), 4);
        chk("R9 err still set", int'(cfg_err), 1);

        // R7 back-to-back writes: last one wins
        wr(1, 7);
        wr(0, 3);
        idle(80);
        #1;
        chk("R7 last write wins core", int'(act_core_sel), 0);
        chk("R7 last write wins sys", int'(act_sys_sel), 3);

        idle(5);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R1..R9 run actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule